// File: doc/BRIEF.md
# Overloadable Command Dispatcher

This block executes one of eight generic register-style commands. A command brings a 3-bit index and two operand words. The low 12 bits of the first operand hold a unit number, and that number picks the attached device that is to carry out the command. What a given command index does therefore depends on which unit it is sent to.

When the unit number names an attached device port, the dispatcher latches the command index and both full operand words. It presents them on a shared device bus and raises the valid line of that one port. It holds the request until the device signals ready, then returns the device's single result word.

A unit number that names no attached port is never sent to a device. Unit 0 is one such number, and so is any number beyond the last port. For these the dispatcher completes on its own. A 2-bit mode input decides the outcome: a trap indication, a zero result or an all-ones result. Only one command is in flight at a time, and a one-cycle done strobe marks each completion.

Top module: `ovl_dispatch`

## Requirements
- R1: The unit number is `req_rs1[11:0]`. Device port k (0-based) answers unit number k+1. An accepted command to unit k+1 raises `dev_valid` bit k alone, in the cycle after acceptance. Bits of rs1 above bit 11 play no part in the selection.
- R2: While a device request is pending, `dev_cmd` carries the accepted command index, `dev_op_a` the full rs1 word and `dev_op_b` the rs2 word. All three stay unchanged until the device answers.
- R3: `req_ready` is high whenever no command is pending, and a request is accepted only when `req_valid` and `req_ready` are both high. From acceptance of a device command until its completion, `req_ready` stays low and `dev_valid` stays asserted until the selected device's `dev_ready` is sampled high.
- R4: When the selected device's `dev_ready` is sampled high at an edge, the next cycle shows `done` high, `trap` low and `result` equal to that device's `dev_result` at that edge.
- R5: A command to an invalid unit with `fb_mode` 2'b00 or 2'b11 completes in the cycle after acceptance with `done` high, `trap` high and `result` zero. No `dev_valid` bit is raised.
- R6: A command to an invalid unit with `fb_mode` 2'b01 completes in the cycle after acceptance with `trap` low and `result` zero.
- R7: A command to an invalid unit with `fb_mode` 2'b10 completes in the cycle after acceptance with `trap` low and `result` all ones.
- R8: A nonzero unit number above the number of device ports is handled exactly like unit 0.
- R9: `done` is a single-cycle strobe per completion. `result` and `trap` keep their values in every cycle in which `done` is low.
- R10: After synchronous reset, `done`, `trap`, `result` and `dev_valid` are zero and `req_ready` is high.
- R11: A `dev_ready` from a port that is not the selected one, or any `dev_ready` while nothing is pending, causes no completion and no change of `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Dispatcher can accept a command |
| req_cmd | input | 3 | Command index 0..7 |
| req_rs1 | input | 32 | First operand; bits [11:0] are the unit number |
| req_rs2 | input | 32 | Second operand |
| fb_mode | input | 2 | Invalid-unit handling: 00/11 trap, 01 zero, 10 all ones |
| done | output | 1 | Completion strobe |
| trap | output | 1 | Completion was a trap |
| result | output | 32 | Result word |
| dev_valid | output | 4 | Per-port request valid |
| dev_cmd | output | 3 | Command index to devices |
| dev_op_a | output | 32 | First operand to devices |
| dev_op_b | output | 32 | Second operand to devices |
| dev_ready | input | 4 | Per-port response ready |
| dev_result | input | 128 | Per-port result words, port k in bits [32k+31:32k] |

## Verification
The completion strobe of one command and the acceptance of the next can land in the same cycle. The bench raises a new request at the very edge where `done` appears. A run of invalid-unit commands therefore gives `done` on consecutive cycles, each with its own result. A second overlap is a stray `dev_ready` from an unselected port during a pending request. The bench forces a fixed device delay while every other port signals ready, and checks that completion comes exactly at the selected device's answer. Each result is compared with a bench-side model of the device function or of the fallback mode.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    FB_TRAP     = 2'b00,
    FB_ZERO     = 2'b01,
    FB_ONES     = 2'b10,
    FB_TRAP_ALT = 2'b11
  } fb_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } disp_state_e;
endpackage

// File: rtl/ovl_unit_decode.sv
module ovl_unit_decode #(
  parameter int UNIT_W    = 12,
  parameter int N_DEV     = 4,
  parameter int UNIT_BASE = 1
) (
  input  logic [UNIT_W-1:0] unit,
  output logic [N_DEV-1:0]  sel,
  output logic              hit
);
  // one comparator per attached port; port k owns unit UNIT_BASE+k
  for (genvar k = 0; k < N_DEV; k++) begin : g_port
    localparam logic [UNIT_W-1:0] PORT_UNIT = UNIT_W'(UNIT_BASE + k);
    assign sel[k] = (unit == PORT_UNIT);
  end

  assign hit = |sel;
endmodule

// File: rtl/ovl_resp_mux.sv
module ovl_resp_mux #(
  parameter int N_DEV = 4,
  parameter int XLEN  = 32
) (
  input  logic [N_DEV-1:0]           grant,
  input  logic [N_DEV-1:0]           dev_ready,
  input  logic [N_DEV-1:0][XLEN-1:0] dev_result,
  output logic                       any_ready,
  output logic [XLEN-1:0]            data
);
  // AND-OR select keyed by the one-hot grant
  always_comb begin
    any_ready = 1'b0;
    data      = '0;
    for (int k = 0; k < N_DEV; k++) begin
      any_ready = any_ready | (grant[k] & dev_ready[k]);
      data      = data | (dev_result[k] & {XLEN{grant[k]}});
    end
  end
endmodule

// File: rtl/ovl_fallback.sv
module ovl_fallback #(
  parameter int XLEN = 32
) (
  input  logic [1:0]      mode,
  output logic            trap,
  output logic [XLEN-1:0] value
);
  import ovl_pkg::*;

  always_comb begin
    unique case (fb_mode_e'(mode))
      FB_ZERO: begin trap = 1'b0; value = '0;           end
      FB_ONES: begin trap = 1'b0; value = {XLEN{1'b1}}; end
      default: begin trap = 1'b1; value = '0;           end
    endcase
  end
endmodule

// File: rtl/ovl_dispatch.sv
module ovl_dispatch #(
  parameter int XLEN      = 32,
  parameter int N_DEV     = 4,
  parameter int UNIT_W    = 12,
  parameter int CMD_W     = 3,
  parameter int UNIT_BASE = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [CMD_W-1:0]           req_cmd,
  input  logic [XLEN-1:0]            req_rs1,
  input  logic [XLEN-1:0]            req_rs2,
  input  logic [1:0]                 fb_mode,
  output logic                       done,
  output logic                       trap,
  output logic [XLEN-1:0]            result,
  output logic [N_DEV-1:0]           dev_valid,
  output logic [CMD_W-1:0]           dev_cmd,
  output logic [XLEN-1:0]            dev_op_a,
  output logic [XLEN-1:0]            dev_op_b,
  input  logic [N_DEV-1:0]           dev_ready,
  input  logic [N_DEV-1:0][XLEN-1:0] dev_result
);
  import ovl_pkg::*;

  disp_state_e            state;
  logic [N_DEV-1:0]       unit_sel;
  logic                   unit_hit;
  logic                   rsp_ready;
  logic [XLEN-1:0]        rsp_data;
  logic                   fb_trap;
  logic [XLEN-1:0]        fb_value;
  logic                   accept;

  ovl_unit_decode #(
    .UNIT_W   (UNIT_W),
    .N_DEV    (N_DEV),
    .UNIT_BASE(UNIT_BASE)
  ) i_decode (
    .unit(req_rs1[UNIT_W-1:0]),
    .sel (unit_sel),
    .hit (unit_hit)
  );

  ovl_resp_mux #(
    .N_DEV(N_DEV),
    .XLEN (XLEN)
  ) i_mux (
    .grant     (dev_valid),
    .dev_ready (dev_ready),
    .dev_result(dev_result),
    .any_ready (rsp_ready),
    .data      (rsp_data)
  );

  ovl_fallback #(
    .XLEN(XLEN)
  ) i_fallback (
    .mode (fb_mode),
    .trap (fb_trap),
    .value(fb_value)
  );

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      done      <= 1'b0;
      trap      <= 1'b0;
      result    <= '0;
      dev_valid <= '0;
      dev_cmd   <= '0;
      dev_op_a  <= '0;
      dev_op_b  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (unit_hit) begin
              // route to the owning port and wait for its answer
              state     <= ST_WAIT;
              req_ready <= 1'b0;
              dev_valid <= unit_sel;
              dev_cmd   <= req_cmd;
              dev_op_a  <= req_rs1;
              dev_op_b  <= req_rs2;
            end else begin
              // no owner: finish locally per fallback mode
              done   <= 1'b1;
              trap   <= fb_trap;
              result <= fb_value;
            end
          end
        end
        ST_WAIT: begin
          if (rsp_ready) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
            dev_valid <= '0;
            done      <= 1'b1;
            trap      <= 1'b0;
            result    <= rsp_data;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ovl_dispatch_chk.sv
module ovl_dispatch_chk #(
  parameter int XLEN      = 32,
  parameter int N_DEV     = 4,
  parameter int UNIT_W    = 12,
  parameter int UNIT_BASE = 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [XLEN-1:0]            req_rs1,
  input logic [XLEN-1:0]            req_rs2,
  input logic [1:0]                 fb_mode,
  input logic                       done,
  input logic                       trap,
  input logic [XLEN-1:0]            result,
  input logic [N_DEV-1:0]           dev_valid,
  input logic [XLEN-1:0]            dev_op_a,
  input logic [XLEN-1:0]            dev_op_b,
  input logic [N_DEV-1:0]           dev_ready,
  input logic [N_DEV-1:0][XLEN-1:0] dev_result
);
  logic             c_hit;
  logic [N_DEV-1:0] c_sel;
  logic             c_rsp;
  logic [XLEN-1:0]  c_rsp_val;
  logic             c_acc;
  int               c_unit;

  always_comb begin
    c_unit = int'(req_rs1[UNIT_W-1:0]);
    c_hit  = (c_unit >= UNIT_BASE) && (c_unit < UNIT_BASE + N_DEV);
    c_sel  = c_hit ? (N_DEV'(1) << (c_unit - UNIT_BASE)) : '0;
    c_acc  = req_valid && req_ready;
    c_rsp     = 1'b0;
    c_rsp_val = '0;
    for (int k = 0; k < N_DEV; k++) begin
      if (dev_valid[k] && dev_ready[k]) begin
        c_rsp     = 1'b1;
        c_rsp_val = dev_result[k];
      end
    end
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_valid)); // R1

  AST_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (c_acc && c_hit) |=> (dev_valid == $past(c_sel)) && (dev_op_a == $past(req_rs1)) && (dev_op_b == $past(req_rs2))); // R2

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    ((|dev_valid) && !c_rsp) |=> $stable(dev_valid) && $stable(dev_op_a) && $stable(dev_op_b)); // R3

  AST_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|dev_valid) |-> !req_ready); // R3

  AST_PASS_RESULT: assert property (@(posedge clk) disable iff (rst)
    c_rsp |=> done && !trap && (result == $past(c_rsp_val))); // R4

  AST_TRAP_MODE: assert property (@(posedge clk) disable iff (rst)
    (c_acc && !c_hit && (fb_mode == 2'b00 || fb_mode == 2'b11)) |=> done && trap && (result == '0) && (dev_valid == '0)); // R5

  AST_ZERO_MODE: assert property (@(posedge clk) disable iff (rst)
    (c_acc && !c_hit && fb_mode == 2'b01) |=> done && !trap && (result == '0)); // R6

  AST_ONES_MODE: assert property (@(posedge clk) disable iff (rst)
    (c_acc && !c_hit && fb_mode == 2'b10) |=> done && !trap && (result == {XLEN{1'b1}})); // R7

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result) && $stable(trap)); // R9

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!c_rsp && !c_acc) |=> !done); // R11
endmodule

bind ovl_dispatch ovl_dispatch_chk #(
  .XLEN     (XLEN),
  .N_DEV    (N_DEV),
  .UNIT_W   (UNIT_W),
  .UNIT_BASE(UNIT_BASE)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_rs1   (req_rs1),
  .req_rs2   (req_rs2),
  .fb_mode   (fb_mode),
  .done      (done),
  .trap      (trap),
  .result    (result),
  .dev_valid (dev_valid),
  .dev_op_a  (dev_op_a),
  .dev_op_b  (dev_op_b),
  .dev_ready (dev_ready),
  .dev_result(dev_result)
);

// File: tb/test_ovl_dispatch.sv
`timescale 1ns/1ps
module test_ovl_dispatch;
  localparam int N  = 4;
  localparam int XL = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_cmd = '0;
  logic [XL-1:0]     req_rs1 = '0;
  logic [XL-1:0]     req_rs2 = '0;
  logic [1:0]        fb_mode = '0;
  logic              done;
  logic              trap;
  logic [XL-1:0]     result;
  logic [N-1:0]      dev_valid;
  logic [2:0]        dev_cmd;
  logic [XL-1:0]     dev_op_a;
  logic [XL-1:0]     dev_op_b;
  logic [N-1:0]      dev_ready = '0;
  logic [N-1:0][XL-1:0] dev_result = '0;

  int total = 0;
  int bad   = 0;
  bit stray = 0;
  int wait_override = -1;
  int wt[N];
  bit act[N];
  int last_wait[N];

  always #2 clk = ~clk;

  ovl_dispatch i_ovl_dispatch (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_rs1(req_rs1), .req_rs2(req_rs2), .fb_mode(fb_mode),
    .done(done), .trap(trap), .result(result), .dev_valid(dev_valid),
    .dev_cmd(dev_cmd), .dev_op_a(dev_op_a), .dev_op_b(dev_op_b),
    .dev_ready(dev_ready), .dev_result(dev_result)
  );

  function automatic logic [XL-1:0] dev_fn(input int k, input logic [2:0] c,
                                           input logic [XL-1:0] a, input logic [XL-1:0] b);
    return (a ^ (b << k)) + ({29'b0, c} * 32'h0101_0101) + XL'(k);
  endfunction

  // device models: answer after a random wait, stray ready on idle ports if asked
  always @(negedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (dev_valid[k]) begin
        if (!act[k]) begin
          act[k] = 1'b1;
          wt[k] = (wait_override >= 0) ? wait_override : int'($urandom % 4);
          last_wait[k] = wt[k];
        end
        if (wt[k] == 0) begin
          dev_ready[k]  <= 1'b1;
          dev_result[k] <= dev_fn(k, dev_cmd, dev_op_a, dev_op_b);
        end else begin
          dev_ready[k]  <= 1'b0;
          dev_result[k] <= $urandom;
          wt[k] = wt[k] - 1;
        end
      end else begin
        act[k] = 1'b0;
        dev_ready[k]  <= stray;
        dev_result[k] <= $urandom;
      end
    end
  end

  task automatic chk(input string r, input logic [XL-1:0] actv, input logic [XL-1:0] expv);
    total++;
    if (actv !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, actv, expv);
    end
  endtask

  // called at a negedge; returns at the negedge where done is seen
  task automatic do_op(input logic [2:0] c, input logic [XL-1:0] a,
                       input logic [XL-1:0] b, input logic [1:0] m);
    int u;
    bit vu;
    int k;
    int n;
    logic [XL-1:0] exp_res;
    logic exp_trap;
    u  = int'(a[11:0]);
    vu = (u >= 1) && (u <= N);
    k  = u - 1;
    chk("R3 ready before request", XL'(req_ready), 1);
    req_valid = 1'b1; req_cmd = c; req_rs1 = a; req_rs2 = b; fb_mode = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (vu) begin
      chk("R1 port select", XL'(dev_valid), XL'(1 << k));
      chk("R2 cmd forwarded", XL'(dev_cmd), XL'(c));
      chk("R2 op_a full rs1", dev_op_a, a);
      chk("R2 op_b", dev_op_b, b);
      chk("R3 busy", XL'(req_ready), 0);
    end else begin
      chk("R8 no port raised", XL'(dev_valid), 0);
    end
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (vu) begin
      exp_res  = dev_fn(k, c, a, b);
      exp_trap = 1'b0;
      chk("R4 latency", XL'(n), XL'(last_wait[k] + 1));
      chk("R4 result", result, exp_res);
      chk("R4 trap", XL'(trap), XL'(exp_trap));
    end else begin
      exp_trap = (m == 2'b00) || (m == 2'b11);
      exp_res  = (m == 2'b10) ? {XL{1'b1}} : '0;
      chk("R5 invalid latency", XL'(n), 0);
      if (exp_trap) begin
        chk("R5 trap", XL'(trap), 1);
        chk("R5 result", result, 0);
      end else if (m == 2'b01) begin
        chk("R6 trap", XL'(trap), 0);
        chk("R6 result", result, 0);
      end else begin
        chk("R7 trap", XL'(trap), 0);
        chk("R7 result", result, exp_res);
      end
    end
    chk("R3 ready after done", XL'(req_ready), 1);
  endtask

  task automatic idle_hold(input int cycles);
    logic [XL-1:0] r0;
    logic t0;
    r0 = result; t0 = trap;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R9 done low when idle", XL'(done), 0);
      chk("R9 result held", result, r0);
      chk("R9 trap held", XL'(trap), XL'(t0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 done", XL'(done), 0);
    chk("R10 ready", XL'(req_ready), 1);
    chk("R10 dev_valid", XL'(dev_valid), 0);
    chk("R10 result", result, 0);
    chk("R10 trap", XL'(trap), 0);

    // R1 R2 R4 each port, upper rs1 bits set
    for (int k = 0; k < N; k++)
      do_op(3'(k + 3), {20'hABC00 + 20'(k), 12'(k + 1)}, 32'h1234_0000 + 32'(k), 2'b00);
    // R5 R6 R7 unit 0 in every mode, back to back
    do_op(3'd1, 32'h0000_0000, 32'h5, 2'b00);
    do_op(3'd2, 32'hFFFF_F000, 32'h6, 2'b11);
    do_op(3'd3, 32'h0001_0000, 32'h7, 2'b01);
    do_op(3'd4, 32'h8000_0000, 32'h8, 2'b10);
    // R8 out-of-range units
    do_op(3'd5, 32'(N + 1), 32'h9, 2'b00);
    do_op(3'd6, 32'h0000_0FFF, 32'hA, 2'b10);
    do_op(3'd7, 32'h0000_0800, 32'hB, 2'b01);
    idle_hold(3);

    // R11 stray ready while idle and while another port is pending
    stray = 1'b1;
    idle_hold(5);
    wait_override = 3;
    do_op(3'd2, 32'h0000_0003, 32'hCAFE_F00D, 2'b00);
    wait_override = -1;
    stray = 1'b0;
    idle_hold(2);

    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      logic [XL-1:0] a;
      int sel;
      a   = $urandom;
      sel = int'($urandom % 8);
      if (sel <= N + 1) a[11:0] = 12'(sel);
      else if (sel == 7) a[11:0] = 12'h000;
      do_op(3'($urandom), a, $urandom, 2'($urandom));
      if ($urandom % 3 == 0) idle_hold(1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule